// File: doc/BRIEF.md
# Card Controller Register Bank with Masked Interrupts

This block is the bus-facing register file of a memory-card host controller. A 32-bit read/write port with 12-bit byte addressing reaches the configuration registers (power, clock divider, command argument, command word, data timer, transfer length and data control). The same port reaches a status word, a write-one-to-clear register, two interrupt masks and a read-only identification window. The response registers, the remaining byte count and the FIFO data word are owned by neighbouring logic, so they are read through input ports. Writes that start work (a command launch, a data-control start, a FIFO push) and reads with side effects (a FIFO pop, a release of a deferred transfer) leave as single-cycle strobes.

The status word has two parts. Its low eleven bits are sticky event flags that the engines set with pulses and that software clears. Its upper bits mirror live conditions. Each of the two interrupt lines is a registered OR of the status bits that its own mask selects.

Top module: `mmc_regbank`

## Requirements
- R1: After reset every stored register reads zero and both interrupt lines are low.
- R2: Power (0x00), clock (0x04) and data control (0x2C) keep the low 8 bits of a write, data length (0x28) keeps the low 16 bits, argument (0x08) and data timer (0x24) keep all 32 bits; each reads back from the next cycle on.
- R3: A write to the command register (0x0C) pulses `cmd_launch` in the write cycle when bit 10 of the written word is 1, and the stored command reads back with bit 10 forced to 0.
- R4: Status (0x34) bits 10:0 are sticky and are set by `evt_set` one cycle after the pulse; bit 9 is reserved and always reads 0; status bits 21:11 follow `live_flags` in the same cycle.
- R5: A write to the clear register (0x38) clears the status bits 10:0 that are 1 in the written value and ignores bits 31:11 of that value; if an event sets a bit in the same cycle that a write clears it, the bit ends up set.
- R6: Masks 0x3C and 0x40 keep bits 21:0; `irq[i]` is high one cycle after (status AND mask i) becomes non-zero and low one cycle after it becomes zero.
- R7: A read of the FIFO count register (0x48) returns (`data_cnt` + 3) >> 2, and 0x30 returns `data_cnt` itself.
- R8: Reads at 0xFE0 to 0xFFC return, one per word, the bytes 0x81, 0x11, 0x04, 0x00, 0x0D, 0xF0, 0x05, 0xB1 in address order.
- R9: A read of status or of FIFO count pulses `release_stb` in the same cycle and returns the value as it stood before the release.
- R10: Any word address from 0x80 to 0xBC reads `fifo_rdata` and pulses `fifo_rd_stb`; a write there pulses `fifo_wr_stb` only while `data_cnt` is non-zero.
- R11: 0x10 reads `resp_cmd`; 0x14, 0x18, 0x1C and 0x20 read response words 0 to 3 (word n in `resp_words` bits 32n+31:32n).
- R12: Unmapped addresses read zero, and writes to them change no register.
- R13: A data control write with bit 0 set pulses `dctrl_start` in the write cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr | input | 1 | Write request for this cycle |
| bus_rd | input | 1 | Read request for this cycle |
| bus_addr | input | 12 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of `bus_rd`, zero otherwise |
| evt_set | input | 11 | Sticky event set pulses for status bits 10:0 |
| live_flags | input | 11 | Live conditions shown at status bits 21:11 |
| data_cnt | input | 16 | Remaining byte count from the data engine |
| fifo_rdata | input | 32 | Word at the head of the FIFO |
| resp_cmd | input | 6 | Index of the last response |
| resp_words | input | 128 | Four response words |
| power_q | output | 8 | Power register |
| clkdiv_q | output | 8 | Clock register |
| arg_q | output | 32 | Command argument |
| cmd_q | output | 32 | Stored command word |
| cmd_launch | output | 1 | Command start strobe |
| dtimer_q | output | 32 | Data timer |
| dlen_q | output | 16 | Transfer length |
| dctrl_q | output | 8 | Data control |
| dctrl_start | output | 1 | Data transfer start strobe |
| fifo_rd_stb | output | 1 | FIFO pop strobe |
| fifo_wr_stb | output | 1 | FIFO push strobe |
| release_stb | output | 1 | Release of a deferred transfer |
| irq | output | 2 | Masked interrupt lines |

## Verification
The bench builds the block with its defaults: a 22-bit status word split into 11 sticky and 11 live bits, a 16-bit length and two interrupt lines. The 16-bit count lets the bench drive 0xFFFF, where the +3 of the word count carries out of 16 bits. The 11/11 split puts the reserved bit 9, the boundary at bit 10/11 of the clear register and a live bit under each mask within reach, so that both sides of the sticky/live boundary are checked.

// File: rtl/mmc_regbank_pkg.sv
package mmc_regbank_pkg;

  localparam int STS_W = 22;
  localparam int EVT_W = 11;
  localparam int LEN_W = 16;

  // bit 9 of the event field is reserved
  localparam logic [EVT_W-1:0] EVT_VALID = 11'h5FF;

  localparam logic [11:0] A_PWR  = 12'h000;
  localparam logic [11:0] A_CLK  = 12'h004;
  localparam logic [11:0] A_ARG  = 12'h008;
  localparam logic [11:0] A_CMD  = 12'h00C;
  localparam logic [11:0] A_RCMD = 12'h010;
  localparam logic [11:0] A_RSP0 = 12'h014;
  localparam logic [11:0] A_RSP1 = 12'h018;
  localparam logic [11:0] A_RSP2 = 12'h01C;
  localparam logic [11:0] A_RSP3 = 12'h020;
  localparam logic [11:0] A_DTIM = 12'h024;
  localparam logic [11:0] A_DLEN = 12'h028;
  localparam logic [11:0] A_DCTL = 12'h02C;
  localparam logic [11:0] A_DCNT = 12'h030;
  localparam logic [11:0] A_STS  = 12'h034;
  localparam logic [11:0] A_CLR  = 12'h038;
  localparam logic [11:0] A_MSK0 = 12'h03C;
  localparam logic [11:0] A_MSK1 = 12'h040;
  localparam logic [11:0] A_FCNT = 12'h048;

  // select indices
  localparam int S_PWR  = 0;
  localparam int S_CLK  = 1;
  localparam int S_ARG  = 2;
  localparam int S_CMD  = 3;
  localparam int S_RCMD = 4;
  localparam int S_RSP  = 5;
  localparam int S_DTIM = 6;
  localparam int S_DLEN = 7;
  localparam int S_DCTL = 8;
  localparam int S_DCNT = 9;
  localparam int S_STS  = 10;
  localparam int S_CLR  = 11;
  localparam int S_MSK0 = 12;
  localparam int S_MSK1 = 13;
  localparam int S_FCNT = 14;
  localparam int S_FIFO = 15;
  localparam int S_ID   = 16;
  localparam int NSEL   = 17;

  localparam int CMD_GO_BIT = 10;
  localparam int DCTL_GO_BIT = 0;

  // words needed to carry a byte count, rounded up
  function automatic logic [31:0] fifo_words(input logic [31:0] bytes);
    return (bytes + 32'd3) >> 2;
  endfunction

  // identification byte for word index 0..7 of the window
  function automatic logic [7:0] id_byte(input logic [2:0] idx);
    case (idx)
      3'd0:    return 8'h81;
      3'd1:    return 8'h11;
      3'd2:    return 8'h04;
      3'd3:    return 8'h00;
      3'd4:    return 8'h0D;
      3'd5:    return 8'hF0;
      3'd6:    return 8'h05;
      default: return 8'hB1;
    endcase
  endfunction

  // response word number for an address in the response range
  function automatic logic [1:0] resp_index(input logic [11:0] a);
    return 2'((a - A_RSP0) >> 2);
  endfunction

endpackage

// File: rtl/mmc_addr_decode.sv
module mmc_addr_decode
  import mmc_regbank_pkg::*;
(
  input  logic [11:0]     addr,
  output logic [NSEL-1:0] sel
);

  always_comb begin
    sel = '0;
    case (addr)
      A_PWR:  sel[S_PWR]  = 1'b1;
      A_CLK:  sel[S_CLK]  = 1'b1;
      A_ARG:  sel[S_ARG]  = 1'b1;
      A_CMD:  sel[S_CMD]  = 1'b1;
      A_RCMD: sel[S_RCMD] = 1'b1;
      A_RSP0, A_RSP1, A_RSP2, A_RSP3: sel[S_RSP] = 1'b1;
      A_DTIM: sel[S_DTIM] = 1'b1;
      A_DLEN: sel[S_DLEN] = 1'b1;
      A_DCTL: sel[S_DCTL] = 1'b1;
      A_DCNT: sel[S_DCNT] = 1'b1;
      A_STS:  sel[S_STS]  = 1'b1;
      A_CLR:  sel[S_CLR]  = 1'b1;
      A_MSK0: sel[S_MSK0] = 1'b1;
      A_MSK1: sel[S_MSK1] = 1'b1;
      A_FCNT: sel[S_FCNT] = 1'b1;
      default: begin
        // FIFO window 0x80..0xBC, ID window 0xFE0..0xFFC, word aligned
        if (addr[11:6] == 6'h02 && addr[1:0] == 2'b00) sel[S_FIFO] = 1'b1;
        if (addr[11:5] == 7'h7F && addr[1:0] == 2'b00) sel[S_ID] = 1'b1;
      end
    endcase
  end

  // R12: an address selects at most one register
  always_comb begin
    onehot_sel_chk: assert ($onehot0(sel));
  end

endmodule

// File: rtl/mmc_status_irq.sv
module mmc_status_irq #(
  parameter int STS_W   = 22,
  parameter int EVT_W   = 11,
  parameter int NUM_IRQ = 2,
  parameter logic [EVT_W-1:0] EVT_VALID = '1,
  localparam int LIVE_W = STS_W - EVT_W
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [EVT_W-1:0]         evt_set,
  input  logic [LIVE_W-1:0]        live_flags,
  input  logic                     clr_wr,
  input  logic [EVT_W-1:0]         clr_bits,
  input  logic [NUM_IRQ-1:0]       mask_wr,
  input  logic [STS_W-1:0]         mask_wdata,
  output logic [STS_W-1:0]         status,
  output logic [NUM_IRQ*STS_W-1:0] mask_flat,
  output logic [NUM_IRQ-1:0]       irq
);

  logic [EVT_W-1:0] evt_q;
  logic [EVT_W-1:0] set_eff;
  logic [EVT_W-1:0] clr_eff;

  assign set_eff = evt_set & EVT_VALID;
  assign clr_eff = clr_wr ? clr_bits : '0;

  // set wins over clear in the same cycle
  always_ff @(posedge clk) begin
    if (!rst_n) evt_q <= '0;
    else        evt_q <= (evt_q & ~clr_eff) | set_eff;
  end

  assign status = {live_flags, evt_q};

  for (genvar g = 0; g < NUM_IRQ; g++) begin : g_line
    logic [STS_W-1:0] mask_q;
    logic             irq_q;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        mask_q <= '0;
        irq_q  <= 1'b0;
      end else begin
        if (mask_wr[g]) mask_q <= mask_wdata;
        irq_q <= |(status & mask_q);
      end
    end

    assign mask_flat[g*STS_W +: STS_W] = mask_q;
    assign irq[g] = irq_q;

    // R6: an empty mask keeps its line low in the following cycle
    mask_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_q == '0) |=> !irq_q);
  end

  // R4: a sticky bit only falls through a clear write
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_wr |=> ((evt_q & $past(evt_q)) == $past(evt_q)));

  // R4: an event pulse shows in the status word one cycle later
  evt_land_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|set_eff) |=> ((evt_q & $past(set_eff)) == $past(set_eff)));

  // R5: cleared bits not set in the same cycle are zero afterwards
  clear_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_wr && |(clr_bits & ~set_eff)) |=> ((evt_q & $past(clr_bits & ~set_eff)) == '0));

endmodule

// File: rtl/mmc_regbank.sv
module mmc_regbank
  import mmc_regbank_pkg::*;
#(
  parameter int NUM_IRQ = 2,
  localparam int LIVE_W = STS_W - EVT_W
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bus_wr,
  input  logic                bus_rd,
  input  logic [11:0]         bus_addr,
  input  logic [31:0]         bus_wdata,
  output logic [31:0]         bus_rdata,
  input  logic [EVT_W-1:0]    evt_set,
  input  logic [LIVE_W-1:0]   live_flags,
  input  logic [LEN_W-1:0]    data_cnt,
  input  logic [31:0]         fifo_rdata,
  input  logic [5:0]          resp_cmd,
  input  logic [127:0]        resp_words,
  output logic [7:0]          power_q,
  output logic [7:0]          clkdiv_q,
  output logic [31:0]         arg_q,
  output logic [31:0]         cmd_q,
  output logic                cmd_launch,
  output logic [31:0]         dtimer_q,
  output logic [LEN_W-1:0]    dlen_q,
  output logic [7:0]          dctrl_q,
  output logic                dctrl_start,
  output logic                fifo_rd_stb,
  output logic                fifo_wr_stb,
  output logic                release_stb,
  output logic [NUM_IRQ-1:0]  irq
);

  logic [NSEL-1:0]            sel;
  logic [NSEL-1:0]            wr_hit;
  logic [NSEL-1:0]            rd_hit;
  logic [STS_W-1:0]           status;
  logic [NUM_IRQ*STS_W-1:0]   mask_flat;
  logic [NUM_IRQ-1:0]         mask_wr;

  mmc_addr_decode u_dec (
    .addr (bus_addr),
    .sel  (sel)
  );

  assign wr_hit = bus_wr ? sel : '0;
  assign rd_hit = bus_rd ? sel : '0;

  for (genvar g = 0; g < NUM_IRQ; g++) begin : g_mwr
    assign mask_wr[g] = wr_hit[S_MSK0 + g];
  end

  mmc_status_irq #(
    .STS_W     (STS_W),
    .EVT_W     (EVT_W),
    .NUM_IRQ   (NUM_IRQ),
    .EVT_VALID (EVT_VALID)
  ) u_sts (
    .clk        (clk),
    .rst_n      (rst_n),
    .evt_set    (evt_set),
    .live_flags (live_flags),
    .clr_wr     (wr_hit[S_CLR]),
    .clr_bits   (bus_wdata[EVT_W-1:0]),
    .mask_wr    (mask_wr),
    .mask_wdata (bus_wdata[STS_W-1:0]),
    .status     (status),
    .mask_flat  (mask_flat),
    .irq        (irq)
  );

  // configuration registers
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      power_q  <= '0;
      clkdiv_q <= '0;
      arg_q    <= '0;
      cmd_q    <= '0;
      dtimer_q <= '0;
      dlen_q   <= '0;
      dctrl_q  <= '0;
    end else begin
      if (wr_hit[S_PWR])  power_q  <= bus_wdata[7:0];
      if (wr_hit[S_CLK])  clkdiv_q <= bus_wdata[7:0];
      if (wr_hit[S_ARG])  arg_q    <= bus_wdata;
      if (wr_hit[S_CMD])  cmd_q    <= bus_wdata & ~(32'd1 << CMD_GO_BIT);
      if (wr_hit[S_DTIM]) dtimer_q <= bus_wdata;
      if (wr_hit[S_DLEN]) dlen_q   <= bus_wdata[LEN_W-1:0];
      if (wr_hit[S_DCTL]) dctrl_q  <= bus_wdata[7:0];
    end
  end

  // strobes toward the engines
  assign cmd_launch  = wr_hit[S_CMD]  & bus_wdata[CMD_GO_BIT];
  assign dctrl_start = wr_hit[S_DCTL] & bus_wdata[DCTL_GO_BIT];
  assign fifo_rd_stb = rd_hit[S_FIFO];
  assign fifo_wr_stb = wr_hit[S_FIFO] & (data_cnt != '0);
  assign release_stb = rd_hit[S_STS] | rd_hit[S_FCNT];

  // read mux
  always_comb begin
    bus_rdata = '0;
    if (rd_hit[S_PWR])  bus_rdata = 32'(power_q);
    if (rd_hit[S_CLK])  bus_rdata = 32'(clkdiv_q);
    if (rd_hit[S_ARG])  bus_rdata = arg_q;
    if (rd_hit[S_CMD])  bus_rdata = cmd_q;
    if (rd_hit[S_RCMD]) bus_rdata = 32'(resp_cmd);
    if (rd_hit[S_RSP])  bus_rdata = resp_words[32*resp_index(bus_addr) +: 32];
    if (rd_hit[S_DTIM]) bus_rdata = dtimer_q;
    if (rd_hit[S_DLEN]) bus_rdata = 32'(dlen_q);
    if (rd_hit[S_DCTL]) bus_rdata = 32'(dctrl_q);
    if (rd_hit[S_DCNT]) bus_rdata = 32'(data_cnt);
    if (rd_hit[S_STS])  bus_rdata = 32'(status);
    if (rd_hit[S_FCNT]) bus_rdata = fifo_words(32'(data_cnt));
    if (rd_hit[S_FIFO]) bus_rdata = fifo_rdata;
    if (rd_hit[S_ID])   bus_rdata = 32'(id_byte(bus_addr[4:2]));
    for (int g = 0; g < NUM_IRQ; g++) begin
      if (rd_hit[S_MSK0 + g]) bus_rdata = 32'(mask_flat[g*STS_W +: STS_W]);
    end
  end

  // R9: the release strobe only comes from a read
  release_rd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    release_stb |-> bus_rd);

  // R10: no FIFO push while the byte count is zero
  fifo_push_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_wr_stb |-> (data_cnt != '0));

  // R3: the stored command never keeps the start bit
  cmd_go_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_hit[S_CMD] |=> !cmd_q[CMD_GO_BIT]);

endmodule

// File: tb/test_mmc_regbank.sv
module test_mmc_regbank;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         bus_wr = 1'b0;
  logic         bus_rd = 1'b0;
  logic [11:0]  bus_addr = '0;
  logic [31:0]  bus_wdata = '0;
  logic [31:0]  bus_rdata;
  logic [10:0]  evt_set = '0;
  logic [10:0]  live_flags = '0;
  logic [15:0]  data_cnt = '0;
  logic [31:0]  fifo_rdata = 32'hC0FFEE11;
  logic [5:0]   resp_cmd = 6'h2A;
  logic [127:0] resp_words = {32'h44444444, 32'h33333333, 32'h22222222, 32'h11111111};
  logic [7:0]   power_q, clkdiv_q, dctrl_q;
  logic [31:0]  arg_q, cmd_q, dtimer_q;
  logic [15:0]  dlen_q;
  logic         cmd_launch, dctrl_start, fifo_rd_stb, fifo_wr_stb, release_stb;
  logic [1:0]   irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;
  logic [31:0] rv;
  logic cap_rel, cap_frd, cap_launch, cap_start, cap_fwr;

  always #10 clk = ~clk;

  mmc_regbank i_mmc_regbank (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .evt_set(evt_set), .live_flags(live_flags), .data_cnt(data_cnt),
    .fifo_rdata(fifo_rdata), .resp_cmd(resp_cmd), .resp_words(resp_words),
    .power_q(power_q), .clkdiv_q(clkdiv_q), .arg_q(arg_q), .cmd_q(cmd_q),
    .cmd_launch(cmd_launch), .dtimer_q(dtimer_q), .dlen_q(dlen_q),
    .dctrl_q(dctrl_q), .dctrl_start(dctrl_start), .fifo_rd_stb(fifo_rd_stb),
    .fifo_wr_stb(fifo_wr_stb), .release_stb(release_stb), .irq(irq)
  );

  // {address, write value, expected readback}
  localparam logic [75:0] VEC [9] = '{
    {12'h000, 32'h12345678, 32'h00000078},   // R2
    {12'h004, 32'hFFFFFFA5, 32'h000000A5},   // R2
    {12'h008, 32'hDEADBEEF, 32'hDEADBEEF},   // R2
    {12'h024, 32'h0BADF00D, 32'h0BADF00D},   // R2
    {12'h028, 32'hABCD1234, 32'h00001234},   // R2
    {12'h02C, 32'h0000FFF2, 32'h000000F2},   // R2
    {12'h03C, 32'hFFFFFFFF, 32'h003FFFFF},   // R6
    {12'h040, 32'h00000A00, 32'h00000A00},   // R6
    {12'h00C, 32'h00000FFF, 32'h00000BFF}    // R3
  };

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    #2;
    cap_launch = cmd_launch; cap_start = dctrl_start; cap_fwr = fifo_wr_stb;
    @(posedge clk);
    #1 bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #2;
    rv = bus_rdata; cap_rel = release_stb; cap_frd = fifo_rd_stb;
    #2 bus_rd = 1'b0;
  endtask

  task automatic pulse_evt(input logic [10:0] b);
    @(negedge clk);
    evt_set = b;
    @(posedge clk);
    #1 evt_set = '0;
  endtask

  task automatic summary;
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: reset state
    rd(12'h000); chk(rv, 0, "R1 power");
    rd(12'h008); chk(rv, 0, "R1 argument");
    rd(12'h00C); chk(rv, 0, "R1 command");
    rd(12'h034); chk(rv, 0, "R1 status");
    rd(12'h03C); chk(rv, 0, "R1 mask0");
    chk(32'(irq), 0, "R1 irq");

    // table walk: write, then read back
    foreach (VEC[i]) begin
      wr(VEC[i][75:64], VEC[i][63:32]);
      rd(VEC[i][75:64]);
      chk(rv, VEC[i][31:0], $sformatf("R2/R3/R6 vector %0d", i));
    end

    // R3: launch strobe only with bit 10
    wr(12'h00C, 32'h00000405); chk(32'(cap_launch), 1, "R3 launch with bit10");
    wr(12'h00C, 32'h00000005); chk(32'(cap_launch), 0, "R3 no launch");

    // R13: data control start strobe
    wr(12'h02C, 32'h00000003); chk(32'(cap_start), 1, "R13 start");
    wr(12'h02C, 32'h00000002); chk(32'(cap_start), 0, "R13 no start");

    // R6: irq timing on mask0 bit 6
    wr(12'h03C, 32'h00000040);
    pulse_evt(11'h040);
    chk(32'(irq), 0, "R6 irq not yet");
    @(posedge clk); #1;
    chk(32'(irq), 1, "R6 irq0 up, irq1 low");
    rd(12'h034); chk(rv, 32'h40, "R4 sticky bit 6");
    chk(32'(cap_rel), 1, "R9 status read release");
    // R5: clear drops it, irq falls a cycle later
    wr(12'h038, 32'h00000040);
    chk(32'(irq), 1, "R6 irq still up");
    @(posedge clk); #1;
    chk(32'(irq), 0, "R6 irq down");
    rd(12'h034); chk(rv, 0, "R5 cleared");

    // R6: live bit 11 under mask1
    @(negedge clk); live_flags = 11'h001;
    @(posedge clk); #1;
    chk(32'(irq), 2, "R6 irq1 from live bit");
    rd(12'h034); chk(rv, 32'h800, "R4 live bit 11");
    @(negedge clk); live_flags = 11'h002;

    // R4: reserved bit 9 stays zero, R5 upper clear bits ignored
    pulse_evt(11'h7FF);
    rd(12'h034); chk(rv, 32'h15FF, "R4 reserved bit9 and live bit12");
    wr(12'h038, 32'hFFFFF800);
    rd(12'h034); chk(rv, 32'h15FF, "R5 upper clear bits ignored");
    wr(12'h038, 32'hFFFFFFFF);
    rd(12'h034); chk(rv, 32'h1000, "R5 clear all low bits");
    @(negedge clk); live_flags = '0;

    // R5: set wins over a clear in the same cycle
    @(negedge clk);
    evt_set = 11'h001; bus_wr = 1'b1; bus_addr = 12'h038; bus_wdata = 32'h1;
    @(posedge clk); #1;
    evt_set = '0; bus_wr = 1'b0;
    rd(12'h034); chk(rv, 32'h1, "R5 set wins");

    // R7: word count
    @(negedge clk); data_cnt = 16'd0;
    rd(12'h048); chk(rv, 0, "R7 count 0");
    chk(32'(cap_rel), 1, "R9 count read release");
    @(negedge clk); data_cnt = 16'd1;
    rd(12'h048); chk(rv, 1, "R7 count 1");
    @(negedge clk); data_cnt = 16'd4;
    rd(12'h048); chk(rv, 1, "R7 count 4");
    @(negedge clk); data_cnt = 16'd5;
    rd(12'h048); chk(rv, 2, "R7 count 5");
    rd(12'h030); chk(rv, 5, "R7 byte count");
    chk(32'(cap_rel), 0, "R9 no release on 0x30");
    @(negedge clk); data_cnt = 16'hFFFF;
    rd(12'h048); chk(rv, 32'h4000, "R7 count max");

    // R8: identification window
    for (int k = 0; k < 8; k++) begin
      logic [7:0] e;
      case (k)
        0: e = 8'h81; 1: e = 8'h11; 2: e = 8'h04; 3: e = 8'h00;
        4: e = 8'h0D; 5: e = 8'hF0; 6: e = 8'h05; default: e = 8'hB1;
      endcase
      rd(12'hFE0 + 12'(4*k)); chk(rv, 32'(e), $sformatf("R8 id %0d", k));
    end

    // R10: FIFO window
    rd(12'h09C); chk(rv, 32'hC0FFEE11, "R10 fifo read");
    chk(32'(cap_frd), 1, "R10 pop strobe");
    rd(12'h0C0); chk(32'(cap_frd), 0, "R10 no pop outside window");
    @(negedge clk); data_cnt = 16'd0;
    wr(12'h080, 32'h1); chk(32'(cap_fwr), 0, "R10 push blocked at zero count");
    @(negedge clk); data_cnt = 16'd3;
    wr(12'h0BC, 32'h1); chk(32'(cap_fwr), 1, "R10 push allowed");

    // R11: responses
    rd(12'h010); chk(rv, 32'h2A, "R11 resp cmd");
    rd(12'h014); chk(rv, 32'h11111111, "R11 resp0");
    rd(12'h020); chk(rv, 32'h44444444, "R11 resp3");
    wr(12'h018, 32'h0);
    rd(12'h018); chk(rv, 32'h22222222, "R11 resp1 not writable");

    // R12: unmapped
    wr(12'h044, 32'hFFFFFFFF);
    wr(12'h04C, 32'hFFFFFFFF);
    rd(12'h044); chk(rv, 0, "R12 unmapped read");
    rd(12'h002); chk(rv, 0, "R12 unaligned read");
    rd(12'h000); chk(rv, 32'h78, "R12 power untouched");
    rd(12'h008); chk(rv, 32'hDEADBEEF, "R12 argument untouched");

    done = 1'b1;
    summary();
    $finish;
  end

endmodule